// File: doc/BRIEF.md
# Paged Register Bridge over MII Management

This block is the target side of a management register port. It answers at one fixed PHY address and uses a few 16-bit MII registers as a window into a larger register space. That space is addressed by an 8-bit page and an 8-bit offset, and each access carries up to 64 bits of data. The serial management framing is decoded elsewhere. The bridge sees a parallel access port with PHY address, register number, write data, write and read strobes, and a registered read result with an acknowledge.

Software first selects a page. For a write it fills the four data words and then writes the command register with the offset and the write bit. For a read it writes the command with the read bit, polls until the pending bits clear, and then reads the data words. On the backend side the bridge holds a request with page, offset, direction and 64-bit write data until the backend pulses done. Read results are stored in the data words.

Top module: `mii_paged_bridge`

## Requirements
- R1: Only accesses whose PHY address equals BRIDGE_ADDR (default 0x1E) have an effect. A write to any other PHY address changes no register. A read at any other PHY address gives mii_rack=0 and mii_rdata=0.
- R2: Register 0x10 holds the page in bits 15:8 and the page-enable flag in bit 0. It reads back those fields, and its other bits read 0.
- R3: A write to register 0x11 with bit 0 or bit 1 set, made while no operation is pending, raises be_req in the next cycle. be_offset then equals bits 15:8 of the written value and be_page equals the stored page. be_req stays high until the cycle in which be_done is sampled high.
- R4: For a write command (bit 0), be_we=1 and be_wdata equals {word3, word2, word1, word0}, taken from registers 0x1B, 0x1A, 0x19 and 0x18 at the time of the command.
- R5: Register 0x11 reads back {offset[7:0], 6'b0, read_pending, write_pending}. The pending bit for the active operation reads 1 until the backend completes, and then reads 0.
- R6: For a read command (bit 1), be_we=0. On completion be_rdata is stored into the data words, with register 0x18 taking bits 15:0 and register 0x1B taking bits 63:48.
- R7: A command written while an operation is pending is ignored: the backend request fields and the stored offset stay unchanged.
- R8: A command with both bit 0 and bit 1 set performs a write.
- R9: After reset every register reads 0 and be_req is 0. A command issued while page enable is 0 still uses the stored page.
- R10: A read at BRIDGE_ADDR of an unmapped register number returns 0x0000 with mii_rack=1.
- R11: A read strobe is answered by mii_rack and mii_rdata in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mii_phyad | input | 5 | PHY address of the access |
| mii_regad | input | 5 | Register number of the access |
| mii_wdata | input | 16 | Write data |
| mii_wr | input | 1 | Write strobe, one cycle |
| mii_rd | input | 1 | Read strobe, one cycle |
| mii_rdata | output | 16 | Registered read data |
| mii_rack | output | 1 | Read acknowledge, one cycle after mii_rd |
| be_req | output | 1 | Backend request, held until be_done |
| be_we | output | 1 | Backend direction, 1 = write |
| be_page | output | 8 | Backend page |
| be_offset | output | 8 | Backend register offset |
| be_wdata | output | 64 | Backend write data |
| be_rdata | input | 64 | Backend read data, valid with be_done |
| be_done | input | 1 | Backend completion pulse |

## Verification
A wrong operation state shows at the ports in two ways. A request can stay high after done, or drop without done. The pending bits can also read back wrong on the very next poll. A stale or wrongly latched operation record shows in be_page, be_offset or be_we in the cycle after the command, and the bench checks these before the backend answers. Word-order faults in the data path show as a swapped halfword on be_wdata, or on the first data-word read after completion. Address-decode faults show as a missing or stray acknowledge one cycle after the read strobe.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam logic [4:0] REG_PAGE  = 5'h10;
  localparam logic [4:0] REG_CMD   = 5'h11;
  localparam logic [4:0] REG_DATA0 = 5'h18;

  typedef struct packed {
    logic [7:0] page;
    logic [7:0] offset;
    logic       we;
  } mpb_op_t;
endpackage

// File: rtl/mpb_regfile.sv
module mpb_regfile #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int PAGE_W = 8,
  localparam int WIDE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [4:0]        regad,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load_en,
  input  logic [WIDE_W-1:0] load_data,
  input  logic [WORD_W-1:0] cmd_rb,
  output logic [PAGE_W-1:0] page,
  output logic              page_en,
  output logic [WIDE_W-1:0] words,
  output logic [WORD_W-1:0] rd_word
);
  import mpb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      page    <= '0;
      page_en <= 1'b0;
    end else if (wr_en && regad == REG_PAGE) begin
      page    <= wdata[WORD_W-1 -: PAGE_W];
      page_en <= wdata[0];
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [4:0] ADDR = REG_DATA0 + 5'(i);
    always_ff @(posedge clk) begin
      if (rst)
        words[i*WORD_W +: WORD_W] <= '0;
      else if (load_en)
        words[i*WORD_W +: WORD_W] <= load_data[i*WORD_W +: WORD_W];
      else if (wr_en && regad == ADDR)
        words[i*WORD_W +: WORD_W] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (regad == REG_PAGE) begin
      rd_word[WORD_W-1 -: PAGE_W] = page;
      rd_word[0] = page_en;
    end else if (regad == REG_CMD) begin
      rd_word = cmd_rb;
    end
    for (int i = 0; i < WORDS; i++)
      if (regad == REG_DATA0 + 5'(i))
        rd_word = words[i*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/mpb_cmd_ctrl.sv
module mpb_cmd_ctrl #(
  parameter int WORD_W = 16,
  parameter int WIDE_W = 64,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [WIDE_W-1:0] words_in,
  input  logic              be_done,
  output logic              be_req,
  output logic              be_we,
  output logic [7:0]        be_page,
  output logic [7:0]        be_offset,
  output logic [WIDE_W-1:0] be_wdata,
  output logic              load_en,
  output logic [WORD_W-1:0] cmd_rb
);
  import mpb_pkg::*;

  mpb_op_t op;
  logic    busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op       <= '0;
      be_wdata <= '0;
    end else if (busy) begin
      if (be_done) busy <= 1'b0;
    end else if (cmd_wr) begin
      op.offset <= cmd_data[WORD_W-1 -: 8];
      if (cmd_data[0] || cmd_data[1]) begin
        busy     <= 1'b1;
        op.we    <= cmd_data[0];
        op.page  <= 8'(page_in);
        be_wdata <= words_in;
      end
    end
  end

  assign be_req    = busy;
  assign be_we     = op.we;
  assign be_page   = op.page;
  assign be_offset = op.offset;
  assign load_en   = busy && be_done && !op.we;

  always_comb begin
    cmd_rb = '0;
    cmd_rb[WORD_W-1 -: 8] = op.offset;
    cmd_rb[0] = busy && op.we;
    cmd_rb[1] = busy && !op.we;
  end
endmodule

// File: rtl/mii_paged_bridge.sv
module mii_paged_bridge #(
  parameter logic [4:0] BRIDGE_ADDR = 5'h1E,
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int PAGE_W = 8,
  localparam int WIDE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mii_phyad,
  input  logic [4:0]        mii_regad,
  input  logic [WORD_W-1:0] mii_wdata,
  input  logic              mii_wr,
  input  logic              mii_rd,
  output logic [WORD_W-1:0] mii_rdata,
  output logic              mii_rack,
  output logic              be_req,
  output logic              be_we,
  output logic [7:0]        be_page,
  output logic [7:0]        be_offset,
  output logic [WIDE_W-1:0] be_wdata,
  input  logic [WIDE_W-1:0] be_rdata,
  input  logic              be_done
);
  import mpb_pkg::*;

  logic              sel;
  logic              load_en;
  logic [WORD_W-1:0] cmd_rb;
  logic [WORD_W-1:0] rd_word;
  logic [PAGE_W-1:0] page;
  logic              page_en;
  logic [WIDE_W-1:0] words;

  assign sel = (mii_phyad == BRIDGE_ADDR);

  mpb_regfile #(.WORD_W(WORD_W), .WORDS(WORDS), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(sel && mii_wr), .regad(mii_regad),
    .wdata(mii_wdata), .load_en(load_en), .load_data(be_rdata),
    .cmd_rb(cmd_rb), .page(page), .page_en(page_en), .words(words),
    .rd_word(rd_word)
  );

  mpb_cmd_ctrl #(.WORD_W(WORD_W), .WIDE_W(WIDE_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_wr(sel && mii_wr && mii_regad == REG_CMD), .cmd_data(mii_wdata),
    .page_in(page), .words_in(words), .be_done(be_done),
    .be_req(be_req), .be_we(be_we), .be_page(be_page),
    .be_offset(be_offset), .be_wdata(be_wdata), .load_en(load_en),
    .cmd_rb(cmd_rb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mii_rack  <= 1'b0;
      mii_rdata <= '0;
    end else begin
      mii_rack  <= sel && mii_rd;
      mii_rdata <= (sel && mii_rd) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter logic [4:0] BRIDGE_ADDR = 5'h1E,
  parameter int WORD_W = 16,
  parameter int WIDE_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        mii_phyad,
  input logic              mii_rd,
  input logic              mii_rack,
  input logic [WORD_W-1:0] mii_rdata,
  input logic              be_req,
  input logic              be_done,
  input logic              be_we,
  input logic [7:0]        be_page,
  input logic [7:0]        be_offset,
  input logic [WIDE_W-1:0] be_wdata
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_done |=> be_req);
  p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
    be_req && be_done |=> !be_req);
  p_fields_stable_r7: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_done |=> $stable(be_page) && $stable(be_offset)
                           && $stable(be_we) && $stable(be_wdata));
  p_foreign_silent_r1: assert property (@(posedge clk) disable iff (rst)
    mii_rd && mii_phyad != BRIDGE_ADDR |=> !mii_rack);
  p_ack_next_r11: assert property (@(posedge clk) disable iff (rst)
    mii_rd && mii_phyad == BRIDGE_ADDR |=> mii_rack);
  p_no_data_without_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !mii_rack |-> mii_rdata == '0);
endmodule

bind mii_paged_bridge mpb_checker #(.BRIDGE_ADDR(BRIDGE_ADDR), .WORD_W(WORD_W),
                                    .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst(rst), .mii_phyad(mii_phyad), .mii_rd(mii_rd),
  .mii_rack(mii_rack), .mii_rdata(mii_rdata), .be_req(be_req),
  .be_done(be_done), .be_we(be_we), .be_page(be_page),
  .be_offset(be_offset), .be_wdata(be_wdata)
);

// File: tb/tb_mii_paged_bridge.sv
module tb_mii_paged_bridge;
  localparam logic [4:0] ADDR = 5'h1E;

  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  mii_phyad = 0, mii_regad = 0;
  logic [15:0] mii_wdata = 0;
  logic        mii_wr = 0, mii_rd = 0;
  logic [15:0] mii_rdata;
  logic        mii_rack;
  logic        be_req, be_we;
  logic [7:0]  be_page, be_offset;
  logic [63:0] be_wdata;
  logic [63:0] be_rdata = 0;
  logic        be_done = 0;

  int errors = 0, checks = 0, lat = 4, bcnt = 0, cycles = 0;
  logic [63:0] last_wr;

  always #10 clk = ~clk;

  mii_paged_bridge dut (.*);

  function automatic logic [63:0] model_rd(input logic [7:0] p, input logic [7:0] o);
    return {p, o, 16'hA5C3 ^ {p, o}, ~{p, o}, {o, p}};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (be_done) begin
      be_done = 0;
      bcnt = 0;
    end else if (be_req) begin
      bcnt++;
      if (bcnt >= lat) begin
        be_done = 1;
        if (be_we) last_wr = be_wdata;
        else be_rdata = model_rd(be_page, be_offset);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mwr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    @(negedge clk);
    mii_phyad = phy; mii_regad = ra; mii_wdata = d; mii_wr = 1;
    @(negedge clk);
    mii_wr = 0;
  endtask

  task automatic mrd(input logic [4:0] phy, input logic [4:0] ra,
                     output logic [15:0] d, output logic ack);
    @(negedge clk);
    mii_phyad = phy; mii_regad = ra; mii_rd = 1;
    @(negedge clk);
    mii_rd = 0;
    d = mii_rdata; ack = mii_rack;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] d; logic a;
    for (int i = 0; i < 200; i++) begin
      mrd(ADDR, 5'h11, d, a);
      if (d[1:0] == 2'b00) return;
    end
    chk(req, 1, 0);
  endtask

  task automatic t_reset;
    logic [15:0] d; logic a;
    chk("R9 be_req", be_req, 0);
    mrd(ADDR, 5'h10, d, a); chk("R9 page", d, 0);
    mrd(ADDR, 5'h11, d, a); chk("R9 cmd", d, 0);
    for (int i = 0; i < 4; i++) begin
      mrd(ADDR, 5'h18 + 5'(i), d, a); chk("R9 data", d, 0);
    end
  endtask

  task automatic t_page_and_decode;
    logic [15:0] d; logic a;
    mwr(ADDR, 5'h10, 16'h37FF);
    mrd(ADDR, 5'h10, d, a); chk("R2 page rb", d, 16'h3701);
    chk("R11 ack", a, 1);
    mwr(5'h01, 5'h10, 16'hAA01);
    mrd(ADDR, 5'h10, d, a); chk("R1 foreign write", d, 16'h3701);
    mrd(5'h01, 5'h10, d, a);
    chk("R1 foreign ack", a, 0); chk("R1 foreign data", d, 0);
    mrd(ADDR, 5'h12, d, a);
    chk("R10 unmapped", d, 0); chk("R10 ack", a, 1);
  endtask

  task automatic t_read_nopage_en;
    logic [15:0] d; logic a;
    logic [63:0] exp = model_rd(8'h45, 8'h9C);
    mwr(ADDR, 5'h10, 16'h4500);
    mwr(ADDR, 5'h11, 16'h9C02);
    chk("R3 req", be_req, 1); chk("R6 dir", be_we, 0);
    chk("R9 page used w/o enable", be_page, 8'h45);
    chk("R3 offset", be_offset, 8'h9C);
    mrd(ADDR, 5'h11, d, a); chk("R5 pending", d, 16'h9C02);
    wait_idle("R5 clear");
    mrd(ADDR, 5'h11, d, a); chk("R5 cleared", d, 16'h9C00);
    for (int i = 0; i < 4; i++) begin
      mrd(ADDR, 5'h18 + 5'(i), d, a); chk("R6 word", d, exp[i*16 +: 16]);
    end
  endtask

  task automatic t_write;
    logic [15:0] d; logic a;
    mwr(ADDR, 5'h10, 16'h1201);
    mwr(ADDR, 5'h18, 16'h0001);
    mwr(ADDR, 5'h19, 16'h2223);
    mwr(ADDR, 5'h1A, 16'h4445);
    mwr(ADDR, 5'h1B, 16'h8867);
    mwr(ADDR, 5'h11, 16'h7701);
    chk("R4 we", be_we, 1); chk("R4 wdata", be_wdata, 64'h8867_4445_2223_0001);
    chk("R3 page", be_page, 8'h12);
    mrd(ADDR, 5'h11, d, a); chk("R5 wr pending", d, 16'h7701);
    wait_idle("R5 wr clear");
    chk("R4 backend got", last_wr, 64'h8867_4445_2223_0001);
  endtask

  task automatic t_both_bits;
    mwr(ADDR, 5'h11, 16'h5503);
    chk("R8 write wins", be_we, 1);
    wait_idle("R8 clear");
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d; logic a;
    logic [63:0] exp = model_rd(8'h12, 8'h22);
    lat = 20;
    mwr(ADDR, 5'h11, 16'h2202);
    mwr(ADDR, 5'h11, 16'h3301);
    chk("R7 we kept", be_we, 0); chk("R7 offset kept", be_offset, 8'h22);
    mrd(ADDR, 5'h11, d, a); chk("R7 cmd rb", d, 16'h2202);
    wait_idle("R7 clear");
    mrd(ADDR, 5'h1B, d, a); chk("R7 read result", d, exp[63:48]);
    lat = 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_page_and_decode();
    t_read_nopage_en();
    t_write();
    t_both_bits();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule